// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the datapath half of a small 32-bit processor that runs each instruction over several short clock cycles. Fetch, decode, execute, memory access and write-back all run in the same hardware. One word-wide memory serves both instruction fetch and data access. One ALU computes next-PC values, branch targets, effective addresses and results. Holding registers keep values between cycles: the instruction register, the memory data register, two operand registers and the ALU result register.

The datapath has no sequencer of its own. An external controller drives a full set of steering and write-enable inputs in every cycle. The datapath returns the opcode of the held instruction and the zero flag of the live ALU result. The program counter can be written without a condition, or only when the ALU result is zero, which lets the controller finish a compare-and-branch. For loading memory, the block has a word-wide write port that works outside the normal access path.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter and all holding registers to zero, so `pc_o` and `alu_out_o` read 0 after reset.
- R2: The memory word address is taken from the PC when `addr_sel`=0 and from the ALU result register when `addr_sel`=1. The instruction register loads the addressed word only in cycles with `ir_wr`=1. `opcode` always shows instruction register bits 31:26.
- R3: The first ALU operand is the PC when `srca_sel`=0 and the A register when it is 1. The second operand is selected by `srcb_sel`: 00 gives the B register, 01 gives the constant 4, 10 gives the extended immediate (instruction bits 15:0), and 11 gives the extended immediate shifted left by two.
- R4: With `ext_signed`=1 the 16-bit immediate is sign-extended. With `ext_signed`=0 it is zero-extended.
- R5: `alu_mode` selects the ALU operation: 00 add, 01 subtract, 11 bitwise OR. Code 10 decodes instruction bits 5:0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Any other function code adds.
- R6: `alu_zero` is 1 exactly when the live ALU result is all zeros. The PC loads when `pc_wr`=1, or when `pc_wr_cond`=1 and `alu_zero`=1. In all other cycles the PC holds its value.
- R7: The new PC value is selected by `pc_src`: 00 the live ALU result, 01 the ALU result register, 10 the jump target {PC[31:28], instruction bits 25:0, 2'b00}. Code 11 behaves like 00.
- R8: A register-file write goes to register field bits 15:11 when `dst_sel`=1 and to bits 20:16 when it is 0. The data written is the memory data register when `wb_sel`=1 and the ALU result register when it is 0. Register 0 always reads zero and ignores writes.
- R9: In every cycle that is not a reset cycle, the A and B registers reload from the registers named by instruction bits 25:21 and 20:16, the memory data register reloads from the addressed memory word, and the ALU result register reloads from the live ALU result. With `mem_wr`=1, B is stored at the selected address.
- R10: With `bd_we`=1, `bd_wdata` is written to memory word `bd_addr`. This write takes priority over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write when the ALU result is zero |
| addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| ir_wr | input | 1 | Instruction register load enable |
| mem_wr | input | 1 | Store B to memory |
| rf_wr | input | 1 | Register-file write enable |
| dst_sel | input | 1 | Destination field: 1 bits 15:11, 0 bits 20:16 |
| wb_sel | input | 1 | Write-back data: 1 memory data register, 0 ALU result register |
| srca_sel | input | 1 | First ALU operand: 0 PC, 1 A |
| srcb_sel | input | 2 | Second ALU operand select |
| alu_mode | input | 2 | ALU operation select |
| ext_signed | input | 1 | 1 sign-extend, 0 zero-extend the immediate |
| pc_src | input | 2 | Next PC source select |
| bd_we | input | 1 | Memory load-port write enable |
| bd_addr | input | MEM_AW | Memory load-port word index |
| bd_wdata | input | 32 | Memory load-port data |
| opcode | output | 6 | Instruction register bits 31:26 |
| alu_zero | output | 1 | Live ALU result equals zero |
| pc_o | output | 32 | Program counter |
| alu_out_o | output | 32 | ALU result register |

## Verification
The assertions assume that every control input holds a known value at every rising edge and that the load port is not used while the datapath runs a program. The register write-back property also assumes that the instruction register is not reloaded in the cycle of the write.

The stimulus meets these assumptions in three ways. The memory is filled only while reset is held. Every later cycle drives a complete control word, built from fixed per-step templates for fetch, decode, execute, memory and write-back. The instruction register is loaded only in fetch cycles, which never write the register file.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREGS  = 1 << REG_AW;
    localparam int IMM_W  = 16;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        AM_ADD   = 2'b00,
        AM_SUB   = 2'b01,
        AM_FUNCT = 2'b10,
        AM_OR    = 2'b11
    } alu_mode_e;

    typedef enum logic [1:0] {
        SB_REG    = 2'b00,
        SB_FOUR   = 2'b01,
        SB_IMM    = 2'b10,
        SB_IMM_SH = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PS_ALU     = 2'b00,
        PS_HELD    = 2'b01,
        PS_JUMP    = 2'b10,
        PS_ALU_ALT = 2'b11
    } pc_src_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic [5:0]        op;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        sh;
        logic [5:0]        fn;
    } instr_t;

    typedef struct packed {
        logic      pc_wr;
        logic      pc_wr_cond;
        logic      addr_sel;
        logic      ir_wr;
        logic      mem_wr;
        logic      rf_wr;
        logic      dst_sel;
        logic      wb_sel;
        logic      srca_sel;
        srcb_e     srcb;
        alu_mode_e mode;
        logic      ext_signed;
        pc_src_e   pc_src;
    } ctl_t;

    function automatic word_t extend_imm(input logic [IMM_W-1:0] imm, input logic sgn);
        return sgn ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} : {{(XLEN-IMM_W){1'b0}}, imm};
    endfunction

    function automatic word_t jump_target(input word_t pc, input logic [25:0] idx);
        return {pc[XLEN-1:XLEN-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
(
    input  word_t      opa,
    input  word_t      opb,
    input  alu_mode_e  mode,
    input  logic [5:0] funct,
    output word_t      result,
    output logic       zero
);

    typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT} op_e;
    op_e op;

    always_comb begin
        unique case (mode)
            AM_ADD: op = OP_ADD;
            AM_SUB: op = OP_SUB;
            AM_OR:  op = OP_OR;
            default: begin
                unique case (funct)
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    default: op = OP_ADD;
                endcase
            end
        endcase
    end

    always_comb begin
        unique case (op)
            OP_SUB:  result = opa - opb;
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_SLT:  result = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: result = opa + opb;
        endcase
    end

    assign zero = (result == '0);

    // R6: a subtract of equal operands must raise the zero flag
    always_comb begin
        if (mode == AM_SUB && opa == opb) begin
            p_sub_equal_zero_r6: assert (zero);
        end
    end

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
    import mcdp_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  word_t             wdata,
    input  logic [REG_AW-1:0] raddr_a,
    input  logic [REG_AW-1:0] raddr_b,
    output word_t             rdata_a,
    output word_t             rdata_b
);

    word_t rd_view [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_cell
        if (g == 0) begin : g_zero
            assign rd_view[g] = '0;
        end else begin : g_store
            word_t q;
            always_ff @(posedge clk) begin
                if (we && waddr == REG_AW'(g)) begin
                    q <= wdata;
                end
            end
            assign rd_view[g] = q;
        end
    end

    assign rdata_a = rd_view[raddr_a];
    assign rdata_b = rd_view[raddr_b];

endmodule

// File: rtl/mcdp_mem.sv
module mcdp_mem
    import mcdp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  word_t         wdata,
    input  logic          bd_we,
    input  logic [AW-1:0] bd_idx,
    input  word_t         bd_wdata,
    output word_t         rdata
);

    localparam int WORDS = 1 << AW;

    word_t cells [WORDS];

    always_ff @(posedge clk) begin
        if (bd_we) begin
            cells[bd_idx] <= bd_wdata;
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mcdp_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_wr,
    input  logic              pc_wr_cond,
    input  logic              addr_sel,
    input  logic              ir_wr,
    input  logic              mem_wr,
    input  logic              rf_wr,
    input  logic              dst_sel,
    input  logic              wb_sel,
    input  logic              srca_sel,
    input  logic [1:0]        srcb_sel,
    input  logic [1:0]        alu_mode,
    input  logic              ext_signed,
    input  logic [1:0]        pc_src,
    input  logic              bd_we,
    input  logic [MEM_AW-1:0] bd_addr,
    input  logic [XLEN-1:0]   bd_wdata,
    output logic [5:0]        opcode,
    output logic              alu_zero,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   alu_out_o
);

    ctl_t ctl;

    always_comb begin
        ctl.pc_wr      = pc_wr;
        ctl.pc_wr_cond = pc_wr_cond;
        ctl.addr_sel   = addr_sel;
        ctl.ir_wr      = ir_wr;
        ctl.mem_wr     = mem_wr;
        ctl.rf_wr      = rf_wr;
        ctl.dst_sel    = dst_sel;
        ctl.wb_sel     = wb_sel;
        ctl.srca_sel   = srca_sel;
        ctl.srcb       = srcb_e'(srcb_sel);
        ctl.mode       = alu_mode_e'(alu_mode);
        ctl.ext_signed = ext_signed;
        ctl.pc_src     = pc_src_e'(pc_src);
    end

    word_t  pc_q, mdr_q, a_q, b_q, alu_out_q;
    instr_t ir_q;

    word_t mem_rdata, rf_a, rf_b, rf_wdata, imm_ext, opa, opb, alu_res, pc_next;
    logic [REG_AW-1:0] rf_waddr;
    logic [MEM_AW-1:0] mem_idx;
    logic              pc_load;

    assign mem_idx = ctl.addr_sel ? alu_out_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

    mcdp_mem #(.AW(MEM_AW)) u_mem (
        .clk      (clk),
        .we       (ctl.mem_wr),
        .idx      (mem_idx),
        .wdata    (b_q),
        .bd_we    (bd_we),
        .bd_idx   (bd_addr),
        .bd_wdata (bd_wdata),
        .rdata    (mem_rdata)
    );

    assign imm_ext = extend_imm(ir_q[IMM_W-1:0], ctl.ext_signed);

    always_comb begin
        opa = ctl.srca_sel ? a_q : pc_q;
        unique case (ctl.srcb)
            SB_REG:    opb = b_q;
            SB_FOUR:   opb = word_t'(4);
            SB_IMM:    opb = imm_ext;
            default:   opb = imm_ext << 2;
        endcase
    end

    mcdp_alu u_alu (
        .opa    (opa),
        .opb    (opb),
        .mode   (ctl.mode),
        .funct  (ir_q.fn),
        .result (alu_res),
        .zero   (alu_zero)
    );

    assign rf_waddr = ctl.dst_sel ? ir_q.rd : ir_q.rt;
    assign rf_wdata = ctl.wb_sel ? mdr_q : alu_out_q;

    mcdp_regfile u_rf (
        .clk     (clk),
        .we      (ctl.rf_wr),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ir_q.rs),
        .raddr_b (ir_q.rt),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    always_comb begin
        unique case (ctl.pc_src)
            PS_HELD: pc_next = alu_out_q;
            PS_JUMP: pc_next = jump_target(pc_q, ir_q[25:0]);
            default: pc_next = alu_res;
        endcase
    end

    assign pc_load = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            ir_q      <= '0;
            mdr_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            alu_out_q <= '0;
        end else begin
            if (pc_load) begin
                pc_q <= pc_next;
            end
            if (ctl.ir_wr) begin
                ir_q <= instr_t'(mem_rdata);
            end
            mdr_q     <= mem_rdata;
            a_q       <= rf_a;
            b_q       <= rf_b;
            alu_out_q <= alu_res;
        end
    end

    assign opcode    = ir_q.op;
    assign pc_o      = pc_q;
    assign alu_out_o = alu_out_q;

    // R2: the instruction register only changes in load cycles
    p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));

    // R6: without a write request the PC keeps its value
    p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc_o));

    // R7: a jump always lands on a word boundary
    p_jump_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10) |=> (pc_o[1:0] == 2'b00));

    // R9: the result register follows the live ALU result one cycle later
    p_aluout_follows_r9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (alu_out_o == $past(alu_res)));

    // R8: a written register shows up in A two cycles later
    p_writeback_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (rf_wr && rf_waddr != '0 && rf_waddr == ir_q.rs && !ir_wr)
        |=> ##1 (a_q == $past(rf_wdata, 2)));

endmodule

// File: tb/mc_datapath_tb_top.sv
module mc_datapath_tb_top;

    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_wr = 0, pc_wr_cond = 0, addr_sel = 0, ir_wr = 0, mem_wr = 0, rf_wr = 0;
    logic dst_sel = 0, wb_sel = 0, srca_sel = 0, ext_signed = 0;
    logic [1:0] srcb_sel = 0, alu_mode = 0, pc_src = 0;
    logic bd_we = 0;
    logic [AW-1:0] bd_addr = '0;
    logic [31:0] bd_wdata = '0;
    logic [5:0]  opcode;
    logic        alu_zero;
    logic [31:0] pc_o, alu_out_o;

    always #10 clk = ~clk;

    mc_datapath #(.MEM_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .addr_sel(addr_sel), .ir_wr(ir_wr), .mem_wr(mem_wr), .rf_wr(rf_wr),
        .dst_sel(dst_sel), .wb_sel(wb_sel), .srca_sel(srca_sel),
        .srcb_sel(srcb_sel), .alu_mode(alu_mode), .ext_signed(ext_signed),
        .pc_src(pc_src), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
        .opcode(opcode), .alu_zero(alu_zero), .pc_o(pc_o), .alu_out_o(alu_out_o)
    );

    typedef struct packed {
        logic pcw, pcc, iord, irw, memw, rfw, dst, wb, sa;
        logic [1:0] sb, mode;
        logic sx;
        logic [1:0] psrc;
    } step_t;

    typedef struct {
        int          when;
        logic [31:0] pc;
        logic [31:0] alu;
        logic [5:0]  op;
        string       tag;
    } exp_t;

    exp_t q[$];
    int edges = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit done = 0;

    logic [31:0] pc_m = 0, ir_m = 0, mdr_m = 0, a_m = 0, b_m = 0, aluo_m = 0;
    logic [31:0] rf_m [32];
    logic [31:0] mem_m [1 << AW];

    always @(posedge clk) edges <= edges + 1;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].when <= edges) begin
            exp_t it;
            it = q.pop_front();
            check(it.tag, "pc", pc_o, it.pc);
            check(it.tag, "alu_out", alu_out_o, it.alu);
            check(it.tag, "opcode", {26'd0, opcode}, {26'd0, it.op});
        end
    end

    function automatic logic [31:0] ref_alu(input logic [1:0] m, input logic [5:0] fn,
                                            input logic [31:0] x, input logic [31:0] y);
        logic [5:0] f;
        f = (m == 2'b00) ? 6'h20 : (m == 2'b01) ? 6'h22 : (m == 2'b11) ? 6'h25 : fn;
        case (f)
            6'h22:   return x - y;
            6'h24:   return x & y;
            6'h25:   return x | y;
            6'h2A:   return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return x + y;
        endcase
    endfunction

    task automatic tick(input step_t c, input string tag);
        logic [31:0] addr, rdw, ext, opa, opb, res, npc, wdat, na, nb;
        logic [4:0]  wreg;
        @(posedge clk); #2;
        rst = 0;
        pc_wr = c.pcw; pc_wr_cond = c.pcc; addr_sel = c.iord; ir_wr = c.irw;
        mem_wr = c.memw; rf_wr = c.rfw; dst_sel = c.dst; wb_sel = c.wb;
        srca_sel = c.sa; srcb_sel = c.sb; alu_mode = c.mode; ext_signed = c.sx; pc_src = c.psrc;
        addr = c.iord ? aluo_m : pc_m;
        rdw  = mem_m[addr[AW+1:2]];
        ext  = c.sx ? {{16{ir_m[15]}}, ir_m[15:0]} : {16'd0, ir_m[15:0]};
        opa  = c.sa ? a_m : pc_m;
        case (c.sb)
            2'b00:   opb = b_m;
            2'b01:   opb = 32'd4;
            2'b10:   opb = ext;
            default: opb = ext << 2;
        endcase
        res = ref_alu(c.mode, ir_m[5:0], opa, opb);
        npc = pc_m;
        if (c.pcw || (c.pcc && res == 32'd0)) begin
            if (c.psrc == 2'b01)      npc = aluo_m;
            else if (c.psrc == 2'b10) npc = {pc_m[31:28], ir_m[25:0], 2'b00};
            else                      npc = res;
        end
        if (c.memw) mem_m[addr[AW+1:2]] = b_m;
        wreg = c.dst ? ir_m[15:11] : ir_m[20:16];
        wdat = c.wb ? mdr_m : aluo_m;
        na = rf_m[ir_m[25:21]];
        nb = rf_m[ir_m[20:16]];
        if (c.rfw && wreg != 5'd0) rf_m[wreg] = wdat;
        mdr_m = rdw;
        if (c.irw) ir_m = rdw;
        a_m = na; b_m = nb; aluo_m = res; pc_m = npc;
        q.push_back('{when: edges + 1, pc: pc_m, alu: aluo_m, op: ir_m[31:26], tag: tag});
    endtask

    task automatic fetch(input string tag);
        step_t c = '0;
        c.pcw = 1; c.irw = 1; c.sb = 2'b01;
        tick(c, tag);
    endtask

    task automatic decode();
        step_t c = '0;
        c.sb = 2'b11; c.sx = 1;
        tick(c, "R4");
    endtask

    task automatic wb_step(input logic dst, input logic wb);
        step_t c = '0;
        c.rfw = 1; c.dst = dst; c.wb = wb; c.sb = 2'b01;
        tick(c, "R8");
    endtask

    task automatic run_r(input string tag);
        step_t c = '0;
        fetch("R2"); decode();
        c.sa = 1; c.mode = 2'b10;
        tick(c, tag);
        wb_step(1'b1, 1'b0);
    endtask

    task automatic run_ori();
        step_t c = '0;
        fetch("R2"); decode();
        c.sa = 1; c.sb = 2'b10; c.mode = 2'b11;
        tick(c, "R4");
        wb_step(1'b0, 1'b0);
    endtask

    task automatic run_mem(input bit is_load);
        step_t c = '0;
        fetch("R2"); decode();
        c.sa = 1; c.sb = 2'b10; c.sx = 1;
        tick(c, "R3");
        c = '0; c.iord = 1; c.sb = 2'b01; c.memw = !is_load;
        tick(c, "R9");
        if (is_load) wb_step(1'b0, 1'b1);
    endtask

    task automatic run_beq();
        step_t c = '0;
        fetch("R2"); decode();
        c.sa = 1; c.mode = 2'b01; c.pcc = 1; c.psrc = 2'b01;
        tick(c, "R6");
    endtask

    task automatic run_j();
        step_t c = '0;
        fetch("R2"); decode();
        c.pcw = 1; c.psrc = 2'b10; c.sb = 2'b01;
        tick(c, "R7");
    endtask

    task automatic load_word(input int idx, input logic [31:0] w);
        @(posedge clk); #2;
        bd_we = 1; bd_addr = AW'(idx); bd_wdata = w;
        mem_m[idx] = w;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf_m[i] = 32'd0;
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = 32'd0;
        load_word(0,  {6'h0D, 5'd0, 5'd1, 16'h8005});
        load_word(1,  {6'h0D, 5'd0, 5'd2, 16'h0003});
        load_word(2,  {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20});
        load_word(3,  {6'h00, 5'd2, 5'd1, 5'd4, 5'd0, 6'h22});
        load_word(4,  {6'h00, 5'd4, 5'd2, 5'd5, 5'd0, 6'h2A});
        load_word(5,  {6'h2B, 5'd0, 5'd3, 16'h0080});
        load_word(6,  {6'h23, 5'd0, 5'd6, 16'h0080});
        load_word(7,  {6'h04, 5'd6, 5'd3, 16'h0002});
        load_word(10, {6'h04, 5'd1, 5'd2, 16'hFFFB});
        load_word(11, {6'h02, 26'h000000E});
        load_word(14, {6'h00, 5'd1, 5'd4, 5'd7, 5'd0, 6'h24});
        load_word(15, {6'h00, 5'd1, 5'd2, 5'd8, 5'd0, 6'h25});
        load_word(16, {6'h0D, 5'd1, 5'd0, 16'h00FF});
        load_word(17, {6'h00, 5'd0, 5'd8, 5'd9, 5'd0, 6'h20});
        load_word(18, {6'h00, 5'd1, 5'd2, 5'd10, 5'd0, 6'h03});
        load_word(19, {6'h23, 5'd3, 5'd11, 16'h8078});
        @(posedge clk); #2;
        bd_we = 0;
        @(negedge clk);
        check("R1", "pc after reset", pc_o, 32'd0);
        check("R1", "alu_out after reset", alu_out_o, 32'd0);
        fetch("R10"); decode();                           // ORI r1 via loaded word, zero-extend
        begin
            step_t c = '0;
            c.sa = 1; c.sb = 2'b10; c.mode = 2'b11;
            tick(c, "R4");
            wb_step(1'b0, 1'b0);
        end
        run_ori();                                        // r2 = 3
        run_r("R5");                                      // add
        run_r("R5");                                      // sub
        run_r("R5");                                      // signed less-than
        run_mem(1'b0);                                    // store r3 at 0x80
        run_mem(1'b1);                                    // load r6 from 0x80
        run_beq();                                        // taken, PC from held result
        run_beq();                                        // not taken, negative offset
        run_j();                                          // R7 jump target
        run_r("R5");                                      // and
        run_r("R5");                                      // or
        run_ori();                                        // write to r0 is dropped
        run_r("R8");                                      // r0 + r8 shows r0 is zero
        run_r("R5");                                      // unknown function code adds
        run_mem(1'b1);                                    // R4 sign-extended address
        begin
            step_t c = '0;
            c.iord = 1; c.sb = 2'b01;
            tick(c, "R2");                                // no IR load while addressing data
        end
        @(posedge clk); #2;
        pc_wr = 0; pc_wr_cond = 0; ir_wr = 0; mem_wr = 0; rf_wr = 0;
        repeat (3) @(negedge clk);
        if (q.size() != 0) check("R9", "pending expectations", 32'(q.size()), 32'd0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

endmodule